// File: doc/BRIEF.md
# BISYNC Receive Block Framer

This block sits behind a character-synchronised BISYNC receiver. It takes one byte per strobe, waits in a sync-hunting state for a SYNC character, and then frames the block that follows. Text bytes go out as buffer writes. A CRC-16 block check runs over the bytes that belong in it. SYNC characters, any DLE characters at the start of a block, and (on request) the header character are kept out of that check.

Each byte is compared with a small control-character table that software programs. The table is searched from entry 0 upward and stops at the first valid entry whose last flag is set. A match ends the block. The matching entry has two flags:
- The first says whether two check bytes follow. If so, they are compared with the running check, and the buffer is then closed with an error flag and the entry number.
- The second says whether the framer hunts for SYNC again afterwards or goes straight on into the next sub-block.

A line-turnaround strobe drops the framer back into hunting at any time. A per-byte character interrupt can be silenced for the body of a block. It comes back on by itself once a control character arrives.

Top module: `bisync_rx_framer`

## Requirements
- R1: After reset the framer is hunting (`hunting`=1), the table holds no valid entry, and `wr_valid`, `char_irq` and `close_valid` are 0.
- R2: While hunting, every byte other than SYNC (default 8'h32) is dropped with no write. A SYNC moves the framer into a block with the check cleared, and that SYNC is not written.
- R3: Inside a block a SYNC byte is neither written nor added to the check.
- R4: DLE bytes (default 8'h10) at the start of a block, before any other non-SYNC byte, are written but not added to the check. A DLE after other text is added.
- R5: A `bcs_reset` pulse clears the check, so bytes received before it (such as a header character) are excluded.
- R6: The table is searched in ascending entry order. The first valid matching entry wins, and entries after the first valid entry with its last flag set are never matched. A byte that matches no searched entry is written and added to the check without ending the block.
- R7: A matching control character is written and added to the check. If its entry has the BCS flag, the next two bytes are taken as the check, low byte first, and are not written. The check is CRC-16 with polynomial x^16+x^15+x^2+1, least significant bit first (reflected constant 16'hA001), initial value 0. When the second check byte arrives, `close_valid` pulses with `close_idx` set to the entry number. `close_crc_err` is 1 exactly when the received pair differs from the computed check.
- R8: A match on an entry without the BCS flag closes the buffer on that same byte, with `close_crc_err`=0.
- R9: After a close the framer hunts if the entry's hunt flag is set. Otherwise it stays in a block with the check cleared and leading-DLE exclusion re-armed.
- R10: A `turnaround` pulse makes `hunting` 1 on the next cycle from any state, with no buffer close.
- R11: An `irq_mask` pulse silences `char_irq` for ordinary written bytes. `char_irq` is always 1 on a matched control character, and the match lifts the mask. While unmasked, every written byte raises `char_irq`.
- R12: Every output event (`wr_valid`, `char_irq`, `close_valid`) appears in the cycle after the clock edge that took the byte causing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Received byte strobe |
| in_byte | input | 8 | Received byte |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_addr | input | $clog2(DEPTH) | Table entry number |
| tbl_chr | input | 8 | Control character for the entry |
| tbl_last | input | 1 | Entry ends the table search |
| tbl_bcs | input | 1 | Two check bytes follow this character |
| tbl_hunt | input | 1 | Hunt for SYNC after the block closes |
| bcs_reset | input | 1 | Clear the running check |
| turnaround | input | 1 | Line turnaround: go back to hunting |
| irq_mask | input | 1 | Silence per-byte interrupts until the next control character |
| wr_valid | output | 1 | Buffer byte write |
| wr_byte | output | 8 | Byte written to the buffer |
| char_irq | output | 1 | Per-byte character interrupt |
| close_valid | output | 1 | Buffer close event |
| close_crc_err | output | 1 | Check mismatch on this close |
| close_idx | output | $clog2(DEPTH) | Table entry that ended the block |
| hunting | output | 1 | Framer is searching for SYNC |

## Verification
The assertions check the structural rules on every cycle:
- An event follows only a consumed byte.
- A byte taken while hunting never produces a write.
- SYNC is never written.
- An interrupt always comes with a write.
- A turnaround always lands in hunting.

Only the bench scenarios can show that the check value is right, including the exclusion of SYNC, leading DLE and the header before a reset. The same holds for first-match table order, the entry number and error flag on each close, the choice between hunting and continuing after a close, and the mask being lifted by a control character.

// File: rtl/bisync_rx_framer.sv
module bisync_rx_framer #(
  parameter int DEPTH = 8,
  parameter logic [7:0] SYNC_CHAR = 8'h32,
  parameter logic [7:0] DLE_CHAR = 8'h10,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_byte,
  input  logic          tbl_we,
  input  logic [IW-1:0] tbl_addr,
  input  logic [7:0]    tbl_chr,
  input  logic          tbl_last,
  input  logic          tbl_bcs,
  input  logic          tbl_hunt,
  input  logic          bcs_reset,
  input  logic          turnaround,
  input  logic          irq_mask,
  output logic          wr_valid,
  output logic [7:0]    wr_byte,
  output logic          char_irq,
  output logic          close_valid,
  output logic          close_crc_err,
  output logic [IW-1:0] close_idx,
  output logic          hunting
);

  localparam logic [1:0] S_HUNT = 2'd0, S_BLK = 2'd1, S_CK1 = 2'd2, S_CK2 = 2'd3;

  logic [7:0]       t_chr [DEPTH];
  logic [DEPTH-1:0] t_vld, t_last, t_bcs, t_hunt;

  logic [1:0]    st;
  logic [15:0]   crc, crc_nx;
  logic          lead, mask, p_hunt;
  logic [7:0]    ck_lo;
  logic [IW-1:0] p_idx;
  logic          hit, stop;
  logic [IW-1:0] hidx;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {8'h00, d};
    for (int b = 0; b < 8; b++)
      r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
    return r;
  endfunction

  assign crc_nx  = crc_step(crc, in_byte);
  assign hunting = (st == S_HUNT);

  always_comb begin
    hit  = 1'b0;
    hidx = '0;
    stop = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!stop && t_vld[i]) begin
        if (t_chr[i] == in_byte) begin
          hit  = 1'b1;
          hidx = IW'(i);
          stop = 1'b1;
        end else if (t_last[i]) begin
          stop = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_vld <= '0; t_last <= '0; t_bcs <= '0; t_hunt <= '0;
    end else if (tbl_we) begin
      t_vld[tbl_addr]  <= 1'b1;
      t_last[tbl_addr] <= tbl_last;
      t_bcs[tbl_addr]  <= tbl_bcs;
      t_hunt[tbl_addr] <= tbl_hunt;
    end
  end

  always_ff @(posedge clk)
    if (tbl_we) t_chr[tbl_addr] <= tbl_chr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_HUNT; crc <= '0; lead <= 1'b0; mask <= 1'b0;
      p_hunt <= 1'b0; p_idx <= '0; ck_lo <= '0;
      wr_valid <= 1'b0; wr_byte <= '0; char_irq <= 1'b0;
      close_valid <= 1'b0; close_crc_err <= 1'b0; close_idx <= '0;
    end else begin
      wr_valid    <= 1'b0;
      char_irq    <= 1'b0;
      close_valid <= 1'b0;
      if (irq_mask) mask <= 1'b1;
      if (turnaround) begin
        st <= S_HUNT;
      end else if (in_valid) begin
        case (st)
          S_HUNT: if (in_byte == SYNC_CHAR) begin
            st <= S_BLK; crc <= '0; lead <= 1'b1;
          end
          S_BLK: if (in_byte != SYNC_CHAR) begin
            wr_valid <= 1'b1;
            wr_byte  <= in_byte;
            char_irq <= !mask || hit;
            if (hit) begin
              mask <= 1'b0;
              if (t_bcs[hidx]) begin
                crc <= crc_nx; p_idx <= hidx; p_hunt <= t_hunt[hidx];
                lead <= 1'b0; st <= S_CK1;
              end else begin
                close_valid <= 1'b1; close_crc_err <= 1'b0; close_idx <= hidx;
                crc <= '0; lead <= 1'b1;
                st <= t_hunt[hidx] ? S_HUNT : S_BLK;
              end
            end else if (!(lead && in_byte == DLE_CHAR)) begin
              crc <= crc_nx; lead <= 1'b0;
            end
          end
          S_CK1: begin
            ck_lo <= in_byte; st <= S_CK2;
          end
          default: begin
            close_valid   <= 1'b1;
            close_crc_err <= ({in_byte, ck_lo} != crc);
            close_idx     <= p_idx;
            crc <= '0; lead <= 1'b1;
            st <= p_hunt ? S_HUNT : S_BLK;
          end
        endcase
      end
      if (bcs_reset) crc <= '0;
    end
  end

endmodule

module bisync_rx_framer_chk #(
  parameter logic [7:0] SYNC_CHAR = 8'h32
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       turnaround,
  input logic       wr_valid,
  input logic [7:0] wr_byte,
  input logic       char_irq,
  input logic       close_valid,
  input logic       hunting
);
  // R12
  wr_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(in_valid));
  // R12
  close_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close_valid |-> $past(in_valid));
  // R2
  no_write_from_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !$past(hunting));
  // R3
  sync_never_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_byte != SYNC_CHAR));
  // R11
  irq_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    char_irq |-> wr_valid);
  // R10
  turnaround_hunts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(turnaround) |-> hunting);
endmodule

bind bisync_rx_framer bisync_rx_framer_chk #(.SYNC_CHAR(SYNC_CHAR)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .turnaround(turnaround),
  .wr_valid(wr_valid), .wr_byte(wr_byte), .char_irq(char_irq),
  .close_valid(close_valid), .hunting(hunting));

// File: tb/bisync_rx_framer_test.sv
module bisync_rx_framer_test;
  localparam logic [7:0] SYN = 8'h32, DLE = 8'h10, SOH = 8'h01;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, tbl_we = 0, tbl_last = 0, tbl_bcs = 0, tbl_hunt = 0;
  logic bcs_reset = 0, turnaround = 0, irq_mask = 0;
  logic [7:0] in_byte = 0, tbl_chr = 0;
  logic [2:0] tbl_addr = 0;
  logic wr_valid, char_irq, close_valid, close_crc_err, hunting;
  logic [7:0] wr_byte;
  logic [2:0] close_idx;

  int checks = 0, errors = 0;
  logic exp_hunt, mask_m;
  logic [15:0] crc_m;
  logic [7:0] term_chr [4] = '{8'h03, 8'h1F, 8'h26, 8'h2D};

  always #2 clk = ~clk;

  bisync_rx_framer uut (.*);

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int b = 0; b < 8; b++) begin
      if (r[0] ^ d[b]) r = (r >> 1) ^ 16'hA001;
      else r = r >> 1;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input bit ew, input bit eirq, input bit ecl,
                      input bit eerr, input logic [2:0] eidx, input string tag);
    @(negedge clk); in_valid = 1; in_byte = b;
    @(negedge clk); in_valid = 0;
    check(wr_valid == ew, {tag, " wr_valid"}, wr_valid, ew);
    if (ew) begin
      check(wr_byte == b, {tag, " wr_byte"}, wr_byte, b);
      check(char_irq == eirq, {tag, " char_irq"}, char_irq, eirq);
    end
    check(close_valid == ecl, {tag, " close_valid"}, close_valid, ecl);
    if (ecl) begin
      check(close_crc_err == eerr, {tag, " crc_err"}, close_crc_err, eerr);
      check(close_idx == eidx, {tag, " close_idx"}, close_idx, eidx);
    end
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) bcs_reset = 1; else if (which == 1) irq_mask = 1; else turnaround = 1;
    @(negedge clk); bcs_reset = 0; irq_mask = 0; turnaround = 0;
  endtask

  task automatic tbl_wr(input logic [2:0] a, input logic [7:0] c, input bit l, input bit bc, input bit h);
    @(negedge clk); tbl_we = 1; tbl_addr = a; tbl_chr = c; tbl_last = l; tbl_bcs = bc; tbl_hunt = h;
    @(negedge clk); tbl_we = 0;
  endtask

  task automatic run_block(input int n, input bit dle, input bit soh, input int term,
                           input bit corrupt, input bit sync_mid, input bit do_mask);
    logic [7:0] b, lo;
    if (exp_hunt) begin
      send(SYN, 0, 0, 0, 0, 0, "R2 sync enters block");
      send(SYN, 0, 0, 0, 0, 0, "R3 sync in block dropped");
    end
    crc_m = 0;
    if (do_mask) begin pulse(1); mask_m = 1; end
    if (dle) send(DLE, 1, !mask_m, 0, 0, 0, "R4 leading dle");
    if (soh) begin
      send(SOH, 1, !mask_m, 0, 0, 0, "R5 soh");
      pulse(0);
    end
    for (int k = 0; k < n; k++) begin
      if (k == 0) b = 8'h41;
      else if (k == 1) b = DLE;
      else begin
        do b = 8'($urandom);
        while (b == SYN || b == DLE || b == 8'h03 || b == 8'h1F || b == 8'h26 || b == 8'h2D);
      end
      if (sync_mid && k == n / 2) send(SYN, 0, 0, 0, 0, 0, "R3 mid sync");
      send(b, 1, !mask_m, 0, 0, 0, k == 0 ? "R6 entry past last" : "R11 data");
      crc_m = ref_crc(crc_m, b);
    end
    crc_m = ref_crc(crc_m, term_chr[term]);
    mask_m = 0;
    if (term == 3) begin
      send(term_chr[term], 1, 1, 1, 0, 3, "R8 no-bcs close");
      exp_hunt = 1;
    end else begin
      send(term_chr[term], 1, 1, 0, 0, 0, "R7 ctrl char");
      lo = crc_m[7:0] ^ (corrupt ? 8'h5A : 8'h00);
      send(lo, 0, 0, 0, 0, 0, "R7 bcs low");
      send(crc_m[15:8], 0, 0, 1, corrupt, 3'(term), "R7 bcs high");
      exp_hunt = (term != 1);
    end
    check(hunting == exp_hunt, "R9 hunting after close", hunting, exp_hunt);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    exp_hunt = 1; mask_m = 0;
    repeat (3) @(negedge clk);
    check(hunting == 1, "R1 hunting", hunting, 1);
    check(wr_valid == 0 && close_valid == 0 && char_irq == 0, "R1 outputs idle",
          {wr_valid, close_valid, char_irq}, 0);
    rst_n = 1;
    send(8'h41, 0, 0, 0, 0, 0, "R2 hunt ignores");
    send(8'h03, 0, 0, 0, 0, 0, "R1 empty table");
    tbl_wr(0, 8'h03, 0, 1, 1);
    tbl_wr(1, 8'h1F, 0, 1, 0);
    tbl_wr(2, 8'h26, 0, 1, 1);
    tbl_wr(3, 8'h2D, 1, 0, 1);
    tbl_wr(4, 8'h41, 1, 0, 1);
    tbl_wr(5, 8'h03, 1, 0, 0);

    run_block(4, 1, 1, 0, 0, 1, 1);
    run_block(3, 0, 0, 3, 0, 0, 0);
    run_block(5, 1, 0, 1, 0, 0, 0);
    run_block(2, 1, 0, 2, 1, 0, 1);
    run_block(3, 0, 1, 0, 1, 0, 0);

    send(SYN, 0, 0, 0, 0, 0, "R10 setup");
    send(8'h41, 1, 1, 0, 0, 0, "R10 setup data");
    pulse(2);
    check(hunting == 1, "R10 turnaround hunts", hunting, 1);
    check(close_valid == 0, "R10 no close", close_valid, 0);
    send(8'h55, 0, 0, 0, 0, 0, "R10 R2 drop after turnaround");
    exp_hunt = 1;

    for (int i = 0; i < 60; i++)
      run_block(2 + int'($urandom_range(8)), 1'($urandom), 1'($urandom),
                int'($urandom_range(3)), ($urandom_range(3) == 0), 1'($urandom), 1'($urandom));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule